// File: doc/BRIEF.md
# Transparent Registered RAM Read Port

This block is a small synchronous RAM with two write ports and one registered read port, all on one clock. The array is read combinationally at the read address. The write data of both ports is then merged into that word bit by bit wherever a write address matches, and the result is captured in an output register. A read therefore returns the data written in the same cycle, while the output register keeps a clock enable, a synchronous reset and a power-up value of its own.

Storage is organised in base words of `BASE_W` bits, and every address counts base words. Each port is `2**LOG2` base words wide. A port of `2**k` words ignores the low `k` bits of its address. Lane `i` of a port's data occupies bits `[i*BASE_W +: BASE_W]` and covers the word at the aligned address plus `i`. With the defaults, the read port is 16 bits wide, write port A is 8 bits wide (narrower than the read port) and write port B is 32 bits wide (wider). Each write port has one enable bit per data bit.

Top module: `xram_rdport`

## Requirements
- R1: Before the first load or reset, `rd_data` equals the parameter `RD_INIT` (default 16'h5AC3).
- R2: When `rd_srst` is 1 at a clock edge, `rd_data` becomes `RD_RSTVAL` (default 16'hE10F) after that edge, whatever `rd_en` and the write ports do.
- R3: When `rd_srst` is 0 and `rd_en` is 0, `rd_data` keeps its value, even if a write hits the words it was read from.
- R4: When `rd_en` is 1 and no write touches the read words, `rd_data` after the edge equals the array contents at the aligned read address: lane 0 is the word at `rd_addr` with bit 0 cleared, and lane 1 is the next word.
- R5: A write in the same cycle to a word being read is forwarded, so `rd_data` shows the new data.
- R6: Forwarding and array update are per bit. Bits whose write-enable bit is 0 keep their old value, both in `rd_data` and in the array.
- R7: When both write ports set the same bit in one cycle, port B's data wins, both in the forwarded read and in the array.
- R8: A wide write (port B, 4 words) forwards only the two lanes that overlap the read words, into the matching read lanes.
- R9: A narrow write (port A, 1 word) forwards into the single read lane whose word it writes, and leaves the other lane unchanged.
- R10: Written data stays in the array and is returned by later reads that have no write in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all ports |
| rd_srst | input | 1 | Synchronous reset of the read register, active high |
| rd_en | input | 1 | Read register clock enable |
| rd_addr | input | ADDR_W | Read address in base words (low RD_LOG2 bits ignored) |
| rd_data | output | BASE_W<<RD_LOG2 | Registered read data |
| wa_addr | input | ADDR_W | Write port A address (low WA_LOG2 bits ignored) |
| wa_data | input | BASE_W<<WA_LOG2 | Write port A data |
| wa_be | input | BASE_W<<WA_LOG2 | Write port A per-bit enables |
| wb_addr | input | ADDR_W | Write port B address (low WB_LOG2 bits ignored) |
| wb_data | input | BASE_W<<WB_LOG2 | Write port B data |
| wb_be | input | BASE_W<<WB_LOG2 | Write port B per-bit enables |

## Verification
The bench goes after same-cycle collisions. A design that registered the address instead of the data would lose the held value while the enable is low. A design that forwarded whole words would corrupt masked bits, and one that chained the ports in the wrong order would let port A win a shared bit. It also aims odd read addresses and unaligned wide writes at every lane pairing: a wrong lane index would forward port B's wrong sub-word, or write port A's byte into both read lanes. A long pseudo-random sweep over the 16-word array, checked against an arithmetic reference model, covers reset and enable combined with every overlap case.

// File: rtl/xram_pkg.sv
package xram_pkg;

    // Widest address the lane helper supports.
    localparam int ADDR_MAX = 16;

    typedef logic [ADDR_MAX-1:0] waddr_t;

    // Action of the read register at a clock edge.
    typedef enum logic [1:0] {
        RQ_HOLD  = 2'd0,
        RQ_LOAD  = 2'd1,
        RQ_CLEAR = 2'd2
    } rq_op_e;

    // Base-word address of one lane of a port that is 2**lg words wide.
    function automatic waddr_t lane_addr(waddr_t a, int lg, int lane);
        waddr_t keep;
        keep = ~((waddr_t'(1) << lg) - waddr_t'(1));
        return (a & keep) | waddr_t'(lane);
    endfunction

    // Reset wins over enable.
    function automatic rq_op_e rq_decide(logic srst, logic en);
        if (srst)
            return RQ_CLEAR;
        if (en)
            return RQ_LOAD;
        return RQ_HOLD;
    endfunction

endpackage

// File: rtl/xram_array.sv
module xram_array
    import xram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BASE_W  = 8,
    parameter int RD_LOG2 = 1,
    parameter int WA_LOG2 = 0,
    parameter int WB_LOG2 = 2
) (
    input  logic                          clk,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [ADDR_W-1:0]             wa_addr,
    input  logic [(BASE_W<<WA_LOG2)-1:0]  wa_data,
    input  logic [(BASE_W<<WA_LOG2)-1:0]  wa_be,
    input  logic [ADDR_W-1:0]             wb_addr,
    input  logic [(BASE_W<<WB_LOG2)-1:0]  wb_data,
    input  logic [(BASE_W<<WB_LOG2)-1:0]  wb_be,
    output logic [(BASE_W<<RD_LOG2)-1:0]  rd_raw
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int RD_LANES = 1 << RD_LOG2;
    localparam int WA_LANES = 1 << WA_LOG2;
    localparam int WB_LANES = 1 << WB_LOG2;

    logic [BASE_W-1:0] mem [DEPTH];

    // Port A is applied first and port B second, so B wins a shared bit.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WA_LANES; i++) begin
            for (int b = 0; b < BASE_W; b++) begin
                if (wa_be[i*BASE_W+b])
                    mem[ADDR_W'(lane_addr(waddr_t'(wa_addr), WA_LOG2, i))][b] <= wa_data[i*BASE_W+b];
            end
        end
        for (int i = 0; i < WB_LANES; i++) begin
            for (int b = 0; b < BASE_W; b++) begin
                if (wb_be[i*BASE_W+b])
                    mem[ADDR_W'(lane_addr(waddr_t'(wb_addr), WB_LOG2, i))][b] <= wb_data[i*BASE_W+b];
            end
        end
    end

    always_comb begin
        for (int j = 0; j < RD_LANES; j++)
            rd_raw[j*BASE_W +: BASE_W] = mem[ADDR_W'(lane_addr(waddr_t'(rd_addr), RD_LOG2, j))];
    end

endmodule

// File: rtl/xram_bypass.sv
module xram_bypass
    import xram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BASE_W  = 8,
    parameter int RD_LOG2 = 1,
    parameter int WR_LOG2 = 0
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [(BASE_W<<RD_LOG2)-1:0]  din,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_data,
    input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_be,
    output logic [(BASE_W<<RD_LOG2)-1:0]  dout
);
    localparam int RD_LANES = 1 << RD_LOG2;
    localparam int WR_LANES = 1 << WR_LOG2;

    // Every read lane is compared with every write lane; each matching
    // pair steers only the bits whose write enable is set.
    always_comb begin
        dout = din;
        for (int j = 0; j < RD_LANES; j++) begin
            for (int i = 0; i < WR_LANES; i++) begin
                if (lane_addr(waddr_t'(rd_addr), RD_LOG2, j) ==
                    lane_addr(waddr_t'(wr_addr), WR_LOG2, i)) begin
                    for (int b = 0; b < BASE_W; b++) begin
                        if (wr_be[i*BASE_W+b])
                            dout[j*BASE_W+b] = wr_data[i*BASE_W+b];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/xram_rdreg.sv
module xram_rdreg
    import xram_pkg::*;
#(
    parameter int           W       = 16,
    parameter logic [W-1:0] INIT_V  = '0,
    parameter logic [W-1:0] RESET_V = '0
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r = INIT_V;
    rq_op_e       op;

    assign op = rq_decide(srst, en);

    always_ff @(posedge clk) begin
        case (op)
            RQ_CLEAR: q_r <= RESET_V;
            RQ_LOAD:  q_r <= d;
            default:  q_r <= q_r;
        endcase
    end

    assign q = q_r;

endmodule

// File: rtl/xram_rdport.sv
module xram_rdport
    import xram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BASE_W  = 8,
    parameter int RD_LOG2 = 1,
    parameter int WA_LOG2 = 0,
    parameter int WB_LOG2 = 2,
    parameter logic [(BASE_W<<RD_LOG2)-1:0] RD_INIT   = 16'h5AC3,
    parameter logic [(BASE_W<<RD_LOG2)-1:0] RD_RSTVAL = 16'hE10F
) (
    input  logic                          clk,
    input  logic                          rd_srst,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [(BASE_W<<RD_LOG2)-1:0]  rd_data,
    input  logic [ADDR_W-1:0]             wa_addr,
    input  logic [(BASE_W<<WA_LOG2)-1:0]  wa_data,
    input  logic [(BASE_W<<WA_LOG2)-1:0]  wa_be,
    input  logic [ADDR_W-1:0]             wb_addr,
    input  logic [(BASE_W<<WB_LOG2)-1:0]  wb_data,
    input  logic [(BASE_W<<WB_LOG2)-1:0]  wb_be
);
    // ADDR_W must not exceed xram_pkg::ADDR_MAX.
    localparam int RD_W = BASE_W << RD_LOG2;

    logic [RD_W-1:0] arr_data;
    logic [RD_W-1:0] fwd_a;
    logic [RD_W-1:0] fwd_b;

    xram_array #(
        .ADDR_W(ADDR_W), .BASE_W(BASE_W), .RD_LOG2(RD_LOG2),
        .WA_LOG2(WA_LOG2), .WB_LOG2(WB_LOG2)
    ) u_array (
        .clk(clk), .rd_addr(rd_addr),
        .wa_addr(wa_addr), .wa_data(wa_data), .wa_be(wa_be),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be),
        .rd_raw(arr_data)
    );

    // Stage order fixes priority: port B's stage sits last.
    xram_bypass #(
        .ADDR_W(ADDR_W), .BASE_W(BASE_W), .RD_LOG2(RD_LOG2), .WR_LOG2(WA_LOG2)
    ) u_fwd_a (
        .rd_addr(rd_addr), .din(arr_data),
        .wr_addr(wa_addr), .wr_data(wa_data), .wr_be(wa_be),
        .dout(fwd_a)
    );

    xram_bypass #(
        .ADDR_W(ADDR_W), .BASE_W(BASE_W), .RD_LOG2(RD_LOG2), .WR_LOG2(WB_LOG2)
    ) u_fwd_b (
        .rd_addr(rd_addr), .din(fwd_a),
        .wr_addr(wb_addr), .wr_data(wb_data), .wr_be(wb_be),
        .dout(fwd_b)
    );

    xram_rdreg #(
        .W(RD_W), .INIT_V(RD_INIT), .RESET_V(RD_RSTVAL)
    ) u_rdreg (
        .clk(clk), .srst(rd_srst), .en(rd_en), .d(fwd_b), .q(rd_data)
    );

endmodule

// File: rtl/xram_checker.sv
module xram_checker #(
    parameter int              ADDR_W = 4,
    parameter int              RD_W   = 16,
    parameter int              WA_W   = 8,
    parameter int              WB_W   = 32,
    parameter logic [RD_W-1:0] RST_V  = '0
) (
    input logic              clk,
    input logic              rd_srst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WA_W-1:0]   wa_be,
    input logic [WB_W-1:0]   wb_be,
    input logic [RD_W-1:0]   arr_data,
    input logic [RD_W-1:0]   rd_data
);
    logic started = 1'b0;
    always_ff @(posedge clk) started <= 1'b1;

    assert_reset_value_R2: assert property (@(posedge clk) disable iff (!started)
        rd_srst |=> rd_data == RST_V);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!started)
        (!rd_srst && !rd_en) |=> $stable(rd_data));

    assert_plain_load_R4: assert property (@(posedge clk) disable iff (!started)
        (!rd_srst && rd_en && wa_be == '0 && wb_be == '0) |=> rd_data == $past(arr_data));

    assert_array_stable_R10: assert property (@(posedge clk) disable iff (!started)
        (wa_be == '0 && wb_be == '0) |=> (rd_addr != $past(rd_addr)) || $stable(arr_data));

endmodule

bind xram_rdport xram_checker #(
    .ADDR_W(ADDR_W),
    .RD_W(RD_W),
    .WA_W(BASE_W << WA_LOG2),
    .WB_W(BASE_W << WB_LOG2),
    .RST_V(RD_RSTVAL)
) u_chk (
    .clk(clk), .rd_srst(rd_srst), .rd_en(rd_en), .rd_addr(rd_addr),
    .wa_be(wa_be), .wb_be(wb_be), .arr_data(arr_data), .rd_data(rd_data)
);

// File: tb/sim_xram_rdport.sv
`timescale 1ns/1ps
module sim_xram_rdport;
    localparam logic [15:0] INITV = 16'h5AC3;
    localparam logic [15:0] RSTV  = 16'hE10F;

    logic        clk = 1'b0;
    logic        rd_srst = 1'b0, rd_en = 1'b0;
    logic [3:0]  rd_addr = '0, wa_addr = '0, wb_addr = '0;
    logic [7:0]  wa_data = '0, wa_be = '0;
    logic [31:0] wb_data = '0, wb_be = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  refm [16];
    logic [15:0] expq = INITV;

    always #10 clk = ~clk;

    xram_rdport u0 (
        .clk(clk), .rd_srst(rd_srst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wa_addr(wa_addr), .wa_data(wa_data), .wa_be(wa_be),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives one cycle and checks after the next rise.
    task automatic step(input string tag, input logic en, input logic srst,
                        input logic [3:0] ra, input logic [3:0] aa,
                        input logic [7:0] ad, input logic [7:0] ab,
                        input logic [3:0] ba, input logic [31:0] bd,
                        input logic [31:0] bb);
        logic [15:0] merged;
        rd_en = en; rd_srst = srst; rd_addr = ra;
        wa_addr = aa; wa_data = ad; wa_be = ab;
        wb_addr = ba; wb_data = bd; wb_be = bb;
        for (int b = 0; b < 8; b++)
            if (ab[b]) refm[aa][b] = ad[b];
        for (int i = 0; i < 4; i++)
            for (int b = 0; b < 8; b++)
                if (bb[i*8+b]) refm[{ba[3:2], 2'(i)}][b] = bd[i*8+b];
        merged = {refm[{ra[3:1], 1'b1}], refm[{ra[3:1], 1'b0}]};
        if (srst) expq = RSTV;
        else if (en) expq = merged;
        @(negedge clk);
        check(tag, rd_data, expq);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        #5;
        check("R1 power-up", rd_data, INITV);
        @(negedge clk);
        step("R1 idle", 0, 0, 4'd0, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0);
        // Fill the array through port B while the register holds.
        for (int k = 0; k < 4; k++)
            step("R3 fill", 0, 0, 4'd0, 4'd0, 8'h00, 8'h00, 4'(k*4),
                 32'h03020100 + 32'h04040404 * k, 32'hFFFFFFFF);
        check("R1 after fill", rd_data, INITV);

        step("R4 odd addr", 1, 0, 4'd3, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0);
        step("R5 same-cycle", 1, 0, 4'd4, 4'd5, 8'hC7, 8'hFF, 4'd0, 32'h0, 32'h0);
        step("R6 masked", 1, 0, 4'd9, 4'd0, 8'h00, 8'h00, 4'd8, 32'hAABBCCDD, 32'h0F0F00F0);
        step("R7 B wins", 1, 0, 4'd6, 4'd6, 8'h11, 8'hFF, 4'd4, 32'h00770000, 32'h00FF0000);
        step("R7 array", 1, 0, 4'd6, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0);
        step("R8 wide", 1, 0, 4'd14, 4'd0, 8'h00, 8'h00, 4'd13, 32'h89ABCDEF, 32'hFFFFFFFF);
        step("R9 narrow", 1, 0, 4'd0, 4'd1, 8'h3C, 8'hFF, 4'd0, 32'h0, 32'h0);
        step("R10 write", 0, 0, 4'd0, 4'd10, 8'h96, 8'hFF, 4'd0, 32'h0, 32'h0);
        step("R10 readback", 1, 0, 4'd11, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0);
        step("R3 hold on hit", 0, 0, 4'd10, 4'd10, 8'h5F, 8'hFF, 4'd8, 32'h12345678, 32'hFFFFFFFF);
        step("R2 over enable", 1, 1, 4'd8, 4'd8, 8'h44, 8'hFF, 4'd0, 32'h0, 32'h0);
        step("R2 no enable", 0, 1, 4'd2, 4'd0, 8'h00, 8'h00, 4'd0, 32'h0, 32'h0);

        for (int n = 0; n < 4000; n++) begin
            logic [3:0]  ra, aa, ba;
            logic [7:0]  ad, ab;
            logic [31:0] bd, bb;
            logic        en, srst, ahit, bhit;
            string       tag;
            ra = 4'($urandom); aa = 4'($urandom); ba = 4'($urandom);
            ad = 8'($urandom); bd = $urandom;
            ab = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            bb = ($urandom % 3 == 0) ? 32'h0 : $urandom;
            en = ($urandom % 4) != 0;
            srst = ($urandom % 16) == 0;
            ahit = (ab != 0) && (aa[3:1] == ra[3:1]);
            bhit = (bb != 0) && (ba[3:2] == ra[3:2]);
            if (srst) tag = "R2 sweep";
            else if (!en) tag = "R3 sweep";
            else if (ahit && bhit) tag = "R7 sweep";
            else if (bhit) tag = "R8 sweep";
            else if (ahit) tag = "R9 sweep";
            else tag = "R4 sweep";
            step(tag, en, srst, ra, aa, ad, ab, ba, bd, bb);
        end
        finish_run();
    end

endmodule